// File: doc/BRIEF.md
# SPI Serial-Clock Divider with Linear and Power-of-Two Modes

This block turns a module clock into the serial clock of an SPI shift engine. A control word holds two divisor fields and a select bit. With the select bit set, the ratio is linear: the module clock is divided by 2(N+1), which gives even ratios from 2 to 512. With it clear, the ratio is a power of two: the module clock is divided by 2^M, for ratios past the linear range.

Alongside the divided clock, the block gives two one-cycle strobes. One marks each edge that leaves the idle level and the other marks each edge that returns to it, so a shift engine can launch and capture data without looking at the clock itself.

A run input frames each transfer. The control word and the polarity are captured when run rises. While run is low the clock rests at the programmed idle level. Software picks the divisor; this block only applies it.

Top module: `spi_sclk_gen`

## Requirements
- R1: With control bit 12 = 1 (linear mode), the serial clock period is 2*(N+1) module-clock cycles, where N is control bits 7:0.
- R2: With bit 12 = 0 (power-of-two mode) and M >= 1, the serial clock period is 2^M module-clock cycles, where M is control bits 11:8.
- R3: In power-of-two mode with M = 0, from the second cycle after the start edge both strobes are high on every cycle, and the serial clock output stays at the active level (inverse of the polarity).
- R4: In the divided modes the duty cycle is 50%: the clock spends exactly half a period at each level, and every level change inside a run comes with a strobe.
- R5: The start edge is the first rising clock edge at which run is sampled high. The first level change and its leading strobe appear exactly one half-period (in module-clock cycles) after the start edge. Each start restarts the count.
- R6: From the cycle after run is sampled low, the serial clock equals the polarity input and neither strobe is asserted.
- R7: The control word and the polarity are sampled only at the start edge. Changes during a run do not alter the ratio until the next start.
- R8: In the divided modes, lead_stb is high for one cycle at each change away from the idle level and trail_stb for one cycle at each change back to it, and the two are never high together.
- R9: The linear limits hold: N = 0 gives a clock that toggles every cycle, with lead and trail strobes alternating; N = 255 gives a ratio of 512.
- R10: With polarity 1 the clock idles high and its first change is to low; with polarity 0 it idles low.
- R11: While reset is high, and in the cycle after it, the serial clock is 0 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run enable; its rising edge starts a run |
| cpol | input | 1 | Idle level of the serial clock |
| ctrl | input | 13 | Control word: N in bits 7:0, M in bits 11:8, mode select in bit 12 |
| sclk | output | 1 | Divided serial clock (registered) |
| lead_stb | output | 1 | One-cycle strobe at each change away from idle |
| trail_stb | output | 1 | One-cycle strobe at each change back to idle |

## Verification
Each run starts at the first edge that samples run high. The first level change lands h edges later, where h is the half-period, and each later change lands h edges after the one before. The outputs are registered, so the bench sets its inputs on falling edges and checks every cycle on the falling edge that follows each rising edge. Cycle j after the start is compared against values worked out from h alone. After run drops, the idle level and quiet strobes are due one edge later, and the bench checks from that falling edge on.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  // Meaning of the mode-select bit of the control word
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;
endpackage

// File: rtl/spi_sclk_ratio.sv
// Decodes the control word into a half-period length and a bypass flag.
module spi_sclk_ratio #(
  parameter int NDIV_W = 8,
  parameter int MDIV_W = 4,
  parameter int CTRL_W = NDIV_W + MDIV_W + 1,
  parameter int HALF_W = 16
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [HALF_W-1:0] half_len,
  output logic              bypass
);
  import spi_sclk_pkg::*;

  localparam int SEL_POS = NDIV_W + MDIV_W;

  logic [NDIV_W-1:0] n_fld;
  logic [MDIV_W-1:0] m_fld;
  div_mode_e         mode;

  assign n_fld = ctrl[NDIV_W-1:0];
  assign m_fld = ctrl[SEL_POS-1:NDIV_W];
  assign mode  = div_mode_e'(ctrl[SEL_POS]);

  always_comb begin
    bypass   = 1'b0;
    half_len = '0;
    if (mode == DIV_LINEAR) begin
      half_len = HALF_W'(n_fld) + HALF_W'(1);
    end else if (m_fld == '0) begin
      bypass   = 1'b1;
      half_len = HALF_W'(1);
    end else begin
      half_len = HALF_W'(1) << (m_fld - MDIV_W'(1));
    end
  end
endmodule

// File: rtl/spi_sclk_timer.sv
// Half-period counter. It is cleared and loaded at the start edge and ticks at each edge time.
module spi_sclk_timer #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              start,
  input  logic [HALF_W-1:0] half_len,
  input  logic              bypass,
  output logic              tick,
  output logic              byp_act
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_q;
  logic              byp_q;
  logic              running;
  logic              at_end;

  assign at_end  = (cnt == half_q - HALF_W'(1));
  assign tick    = running && run && (byp_q || at_end);
  assign byp_act = byp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      half_q  <= HALF_W'(1);
      byp_q   <= 1'b0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      half_q  <= half_len;
      byp_q   <= bypass;
      running <= 1'b1;
    end else if (!run) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (running) begin
      cnt <= at_end ? '0 : cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/spi_sclk_phase.sv
// Registered clock level and edge strobes.
module spi_sclk_phase (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic start,
  input  logic cpol,
  input  logic bypass_now,
  input  logic byp_act,
  input  logic tick,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb
);
  logic pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q     <= 1'b0;
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (start) begin
      pol_q     <= cpol;
      sclk      <= bypass_now ? ~cpol : cpol;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!run) begin
      sclk      <= cpol;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (tick) begin
      if (byp_act) begin
        lead_stb  <= 1'b1;
        trail_stb <= 1'b1;
      end else begin
        lead_stb  <= (sclk == pol_q);
        trail_stb <= (sclk != pol_q);
        sclk      <= ~sclk;
      end
    end else begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int NDIV_W = 8,
  parameter int MDIV_W = 4,
  localparam int CTRL_W = NDIV_W + MDIV_W + 1,
  localparam int POW_W  = (1 << MDIV_W) - 1,
  localparam int HALF_W = (POW_W > NDIV_W + 1) ? POW_W : NDIV_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cpol,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb
);
  logic              run_q;
  logic              start;
  logic [HALF_W-1:0] half_len;
  logic              bypass;
  logic              tick;
  logic              byp_act;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run;
  end

  assign start = run && !run_q;

  spi_sclk_ratio #(
    .NDIV_W(NDIV_W), .MDIV_W(MDIV_W), .CTRL_W(CTRL_W), .HALF_W(HALF_W)
  ) u_ratio (
    .ctrl(ctrl), .half_len(half_len), .bypass(bypass)
  );

  spi_sclk_timer #(.HALF_W(HALF_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .start(start),
    .half_len(half_len), .bypass(bypass), .tick(tick), .byp_act(byp_act)
  );

  spi_sclk_phase u_phase (
    .clk(clk), .rst(rst), .run(run), .start(start), .cpol(cpol),
    .bypass_now(bypass), .byp_act(byp_act), .tick(tick),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );
endmodule

// File: rtl/spi_sclk_gen_checker.sv
module spi_sclk_gen_checker (
  input logic clk,
  input logic rst,
  input logic run,
  input logic cpol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  // R6: after a cycle with run low, the clock is idle and there are no strobes
  assert_idle_when_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == $past(cpol) && !lead_stb && !trail_stb));

  // R8: a strobe on its own marks a real level change
  assert_lead_moves_clock_R8: assert property (@(posedge clk) disable iff (rst)
    (lead_stb && !trail_stb) |-> (sclk != $past(sclk)));

  assert_trail_moves_clock_R8: assert property (@(posedge clk) disable iff (rst)
    (trail_stb && !lead_stb) |-> (sclk != $past(sclk)));

  // R8: a lone leading strobe lasts a single cycle
  assert_lead_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (lead_stb && !trail_stb) |=> !lead_stb);

  // R4: every level change inside a run is announced by a strobe
  assert_change_has_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && $past(run, 2) && sclk != $past(sclk)) |-> (lead_stb || trail_stb));
endmodule

bind spi_sclk_gen spi_sclk_gen_checker u_chk (
  .clk(clk), .rst(rst), .run(run), .cpol(cpol),
  .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic [12:0] ctrl = '0;
  logic        sclk, lead_stb, trail_stb;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sclk_gen uut (
    .clk(clk), .rst(rst), .run(run), .cpol(cpol), .ctrl(ctrl),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  function automatic logic [12:0] lin_word(input int n);
    return {1'b1, 4'd0, 8'(n)};
  endfunction

  function automatic logic [12:0] pow_word(input int m);
    return {1'b0, 4'(m), 8'hA5};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string req, input int j, input logic e_s,
                            input logic e_l, input logic e_t);
    check(sclk == e_s, req, $sformatf("sclk cycle %0d", j), int'(sclk), int'(e_s));
    check(lead_stb == e_l, req, $sformatf("lead cycle %0d", j), int'(lead_stb), int'(e_l));
    check(trail_stb == e_t, req, $sformatf("trail cycle %0d", j), int'(trail_stb), int'(e_t));
  endtask

  // R6: stop the run and check the idle state for a few cycles
  task automatic stop_and_idle(input logic pol);
    run = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_outs("R6", k, pol, 1'b0, 1'b0);
    end
  endtask

  // Divided mode: half-period h, cycle j counted from the start edge
  task automatic run_divided(input string req, input logic [12:0] w, input logic pol,
                             input int h, input int cycles, input int chg_at,
                             input logic [12:0] w2);
    @(negedge clk);
    ctrl = w; cpol = pol; run = 1'b1;
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      begin
        int t = j / h;
        bit at_edge = (j > 0) && (j % h == 0);
        check_outs(req, j, pol ^ t[0], at_edge && t[0], at_edge && !t[0]);
      end
      if (j == chg_at) begin
        ctrl = w2; cpol = ~pol;   // R7: ignored until the next start
      end
    end
    stop_and_idle(cpol);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_outs("R11", 0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_outs("R11", 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic test_bypass(input logic pol);
    @(negedge clk);
    ctrl = pow_word(0); cpol = pol; run = 1'b1;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      check_outs("R3", j, ~pol, j > 0, j > 0);
    end
    stop_and_idle(pol);
  endtask

  initial begin
    test_reset();
    run_divided("R1", lin_word(3), 1'b0, 4, 60, -1, '0);
    run_divided("R9", lin_word(0), 1'b0, 1, 40, -1, '0);
    run_divided("R9", lin_word(255), 1'b0, 256, 1100, -1, '0);
    run_divided("R10", lin_word(1), 1'b1, 2, 30, -1, '0);
    run_divided("R2", pow_word(1), 1'b0, 1, 20, -1, '0);
    run_divided("R2", pow_word(4), 1'b1, 8, 100, -1, '0);
    run_divided("R2", pow_word(9), 1'b0, 256, 1100, -1, '0);
    run_divided("R4", pow_word(15), 1'b0, 16384, 32780, -1, '0);
    run_divided("R7", lin_word(2), 1'b0, 3, 60, 10, lin_word(7));
    run_divided("R5", lin_word(7), 1'b1, 8, 50, -1, '0);
    test_bypass(1'b0);
    test_bypass(1'b1);
    run_divided("R8", lin_word(5), 1'b0, 6, 40, -1, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule